// File: doc/BRIEF.md
# Multi-Mode Link Test Word Generator

This block sits in front of a serial link's framing logic and decides what the link carries: live converter samples, or one of several synthetic patterns used to bring up and qualify the link. A 4-bit mode input picks the source. For every cycle with the input valid flag high, the block emits one registered 16-bit word. The output valid flag follows the input valid flag one cycle later in every mode.

The pattern sources are:
- a fixed pair of alternating bit patterns (checkerboard and all-ones/all-zeros toggle);
- five maximal-length pseudo-random bit sequences of different lengths, sharing one selector;
- a free-running ramp;
- a four-word user pattern, loaded through a small write port and sent either in a loop or exactly once.

Sequencing is held in an enumerated state machine. Its states are PASS, CHECK, TOGGLE, PRBS, RAMP, USER_LOOP, USER_ONCE and ONCE_DONE.
- Any change of the mode input is the "restart" transition. It enters the state that belongs to the new mode and clears the pattern state.
- USER_ONCE moves to ONCE_DONE on the valid word that carries the last user word.
- ONCE_DONE is left only through a restart.
- All other states loop on themselves.

Top module: `lnk_tpg_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `word_vld` is 0 and `word_out` is 0x0000.
- R2: Mode 0000 passes `samp_in` to `word_out` one cycle after a valid input. Every unlisted mode code (1001 to 1101) behaves exactly like 0000.
- R3: Mode 0001 emits 0xAAAA on its first valid word after a restart, then alternates 0x5555 and 0xAAAA on each further valid word.
- R4: Mode 0010 emits 0xFFFF on its first valid word after a restart, then alternates 0x0000 and 0xFFFF.
- R5: Modes 0011, 0100, 0101, 0110 and 0111 select the polynomials x^31+x^28+1, x^23+x^18+1, x^15+x^14+1, x^9+x^5+1 and x^7+x^6+1. Each is an N-bit Fibonacci shift register s, seeded all ones. One bit step forms fb = s[N-1] xor s[T-1] (T being the middle exponent), emits fb, and shifts it into s[0]. A word takes 16 steps, and the first emitted bit lands in word bit 15.
- R6: The x^7 sequence repeats with a period of exactly 127 words, and the x^9 sequence with a period of exactly 511 words. All words within one period are distinct.
- R7: Mode 1000 emits 0x0000 on its first valid word after a restart, adds 1 per valid word, and wraps from 0xFFFF to 0x0000.
- R8: A pulse on `uw_wr` stores `uw_data` as user word `uw_addr` (0 to 3). The stored word is usable from the next cycle. Mode 1110 sends user words 0,1,2,3,0,1,… starting at word 0.
- R9: Mode 1111 sends user words 0 to 3 once, then 0x0000 on every further valid word until the mode input changes.
- R10: A change of the mode input restarts that mode's sequence: PRBS seed, ramp value, alternation phase and user index. This holds even if the change happens on a cycle without valid input.
- R11: `word_vld` equals the previous cycle's `samp_vld`. Cycles without valid input neither advance any pattern nor change `word_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 4 | Pattern source code |
| samp_in | input | 16 | Converter sample word |
| samp_vld | input | 1 | Sample word valid |
| uw_wr | input | 1 | User word write strobe |
| uw_addr | input | 2 | User word index |
| uw_data | input | 16 | User word value |
| word_out | output | 16 | Generated link word |
| word_vld | output | 1 | Generated word valid |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a four-entry user pattern. At 16 bits, a full ramp wrap takes only 65,536 valid words, so the bench drives the ramp through its wrap. The same width makes the full periods of the two shortest pseudo-random sequences cheap to capture and compare. The longer polynomials are checked word for word against the bench's own shift-register model over their opening stretch, across mode switches and idle gaps.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int unsigned NUM_PRBS = 5;

    typedef enum logic [2:0] {
        ST_PASS      = 3'd0,
        ST_CHECK     = 3'd1,
        ST_TOGGLE    = 3'd2,
        ST_PRBS      = 3'd3,
        ST_RAMP      = 3'd4,
        ST_USER_LOOP = 3'd5,
        ST_USER_ONCE = 3'd6,
        ST_ONCE_DONE = 3'd7
    } tpg_state_e;

    // Register length of each polynomial, indexed by (mode - 3)
    function automatic int prbs_len(input int idx);
        case (idx)
            0:       return 31;
            1:       return 23;
            2:       return 15;
            3:       return 9;
            default: return 7;
        endcase
    endfunction

    // Middle exponent (feedback tap) of each polynomial
    function automatic int prbs_tap(input int idx);
        case (idx)
            0:       return 28;
            1:       return 18;
            2:       return 14;
            3:       return 5;
            default: return 6;
        endcase
    endfunction

    function automatic tpg_state_e entry_state(input logic [3:0] m);
        case (m)
            4'h1:                      return ST_CHECK;
            4'h2:                      return ST_TOGGLE;
            4'h3, 4'h4, 4'h5,
            4'h6, 4'h7:                return ST_PRBS;
            4'h8:                      return ST_RAMP;
            4'hE:                      return ST_USER_LOOP;
            4'hF:                      return ST_USER_ONCE;
            default:                   return ST_PASS;
        endcase
    endfunction

endpackage

// File: rtl/tpg_prbs_lane.sv
module tpg_prbs_lane #(
    parameter int unsigned LEN    = 7,
    parameter int unsigned TAP    = 6,
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    output logic [WORD_W-1:0] word
);

    logic [LEN-1:0] st_q;
    logic [LEN-1:0] st_nxt;

    // Produce WORD_W serial steps from the current (or freshly seeded) state
    always_comb begin
        logic [LEN-1:0] s;
        logic           fb;
        s    = restart ? {LEN{1'b1}} : st_q;
        word = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            fb                = s[LEN-1] ^ s[TAP-1];
            word[WORD_W-1-i]  = fb;
            s                 = {s[LEN-2:0], fb};
        end
        st_nxt = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= {LEN{1'b1}};
        end else if (advance) begin
            st_q <= st_nxt;
        end else if (restart) begin
            st_q <= {LEN{1'b1}};
        end
    end

    // R5: a maximal-length register never reaches the all-zero lockup state
    a_r5_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);

    // R10: a restart without a word leaves the register at its seed
    a_r10_lane_reseed: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !advance) |=> (st_q == {LEN{1'b1}}));

endmodule

// File: rtl/tpg_user_bank.sv
module tpg_user_bank #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] bank_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) bank_q[i] <= '0;
        end else if (wr_en) begin
            bank_q[wr_addr] <= wr_data;
        end
    end

    assign rd_word = bank_q[rd_idx];

    // R8: a write lands in the addressed entry on the next cycle
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (bank_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/tpg_seq_fsm.sv
module tpg_seq_fsm
    import tpg_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode,
    input  logic              samp_vld,
    output tpg_state_e        cur_st,
    output logic              restart,
    output logic              phase,
    output logic [WORD_W-1:0] ramp,
    output logic [AW-1:0]     user_idx
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [3:0]        mode_q;
    tpg_state_e        state_q, state_n;
    logic              phase_q, phase_n;
    logic [WORD_W-1:0] ramp_q, ramp_n;
    logic [AW-1:0]     idx_q, idx_n;

    // Effective state for this cycle: a mode change restarts everything
    always_comb begin
        restart  = (mode != mode_q);
        cur_st   = restart ? entry_state(mode) : state_q;
        phase    = restart ? 1'b0 : phase_q;
        ramp     = restart ? '0   : ramp_q;
        user_idx = restart ? '0   : idx_q;
    end

    // Transition logic
    always_comb begin
        state_n = cur_st;
        phase_n = phase;
        ramp_n  = ramp;
        idx_n   = user_idx;
        if (samp_vld) begin
            unique case (cur_st)
                ST_CHECK, ST_TOGGLE: phase_n = ~phase;
                ST_RAMP:             ramp_n  = ramp + 1'b1;
                ST_USER_LOOP:        idx_n   = (user_idx == LAST_IDX) ? '0 : user_idx + 1'b1;
                ST_USER_ONCE: begin
                    if (user_idx == LAST_IDX) begin
                        state_n = ST_ONCE_DONE;
                        idx_n   = '0;
                    end else begin
                        idx_n   = user_idx + 1'b1;
                    end
                end
                ST_PASS, ST_PRBS, ST_ONCE_DONE: ;
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 4'h0;
            state_q <= ST_PASS;
            phase_q <= 1'b0;
            ramp_q  <= '0;
            idx_q   <= '0;
        end else begin
            mode_q  <= mode;
            state_q <= state_n;
            phase_q <= phase_n;
            ramp_q  <= ramp_n;
            idx_q   <= idx_n;
        end
    end

    // R9: once finished, the single-shot state holds until the mode changes
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ONCE_DONE && !restart) |=> (state_q == ST_ONCE_DONE));

    // R7: the ramp advances by exactly one per valid ramp word
    a_r7_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_RAMP && samp_vld) |=> (ramp_q == $past(ramp) + 1'b1));

    // R11: no valid input, no movement of the ramp
    a_r11_ramp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_RAMP && !samp_vld) |=> (ramp_q == $past(ramp)));

    // R10: the registered mode tracks the input
    a_r10_mode_track: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (mode_q == $past(mode)));

endmodule

// File: rtl/lnk_tpg_top.sv
module lnk_tpg_top
    import tpg_pkg::*;
#(
    parameter int unsigned WORD_W     = 16,
    parameter int unsigned USER_DEPTH = 4,
    localparam int unsigned AW        = $clog2(USER_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_sel,
    input  logic [WORD_W-1:0] samp_in,
    input  logic              samp_vld,
    input  logic              uw_wr,
    input  logic [AW-1:0]     uw_addr,
    input  logic [WORD_W-1:0] uw_data,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld
);

    localparam logic [WORD_W-1:0] PAT_CHK_A = {(WORD_W/2){2'b10}};
    localparam logic [WORD_W-1:0] PAT_CHK_B = {(WORD_W/2){2'b01}};

    tpg_state_e        cur_st;
    logic              restart;
    logic              phase;
    logic [WORD_W-1:0] ramp;
    logic [AW-1:0]     user_idx;
    logic [WORD_W-1:0] user_word;
    logic [WORD_W-1:0] prbs_word;
    logic [WORD_W-1:0] nxt_word;
    logic [2:0]        prbs_sel;
    logic [WORD_W-1:0] lane_word [NUM_PRBS];

    assign prbs_sel = 3'(mode_sel - 4'd3);

    tpg_seq_fsm #(
        .WORD_W (WORD_W),
        .DEPTH  (USER_DEPTH)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_sel),
        .samp_vld (samp_vld),
        .cur_st   (cur_st),
        .restart  (restart),
        .phase    (phase),
        .ramp     (ramp),
        .user_idx (user_idx)
    );

    tpg_user_bank #(
        .WORD_W (WORD_W),
        .DEPTH  (USER_DEPTH)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (uw_wr),
        .wr_addr (uw_addr),
        .wr_data (uw_data),
        .rd_idx  (user_idx),
        .rd_word (user_word)
    );

    for (genvar g = 0; g < int'(NUM_PRBS); g++) begin : g_lane
        localparam int unsigned LN = prbs_len(g);
        localparam int unsigned TP = prbs_tap(g);
        logic adv;
        assign adv = samp_vld && (cur_st == ST_PRBS) && (prbs_sel == 3'(g));
        tpg_prbs_lane #(
            .LEN    (LN),
            .TAP    (TP),
            .WORD_W (WORD_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .advance (adv),
            .word    (lane_word[g])
        );
    end

    always_comb begin
        prbs_word = '0;
        for (int i = 0; i < int'(NUM_PRBS); i++) begin
            if (prbs_sel == 3'(i)) prbs_word = lane_word[i];
        end
    end

    // Output selection per state
    always_comb begin
        unique case (cur_st)
            ST_PASS:                    nxt_word = samp_in;
            ST_CHECK:                   nxt_word = phase ? PAT_CHK_B : PAT_CHK_A;
            ST_TOGGLE:                  nxt_word = phase ? '0 : '1;
            ST_PRBS:                    nxt_word = prbs_word;
            ST_RAMP:                    nxt_word = ramp;
            ST_USER_LOOP, ST_USER_ONCE: nxt_word = user_word;
            ST_ONCE_DONE:               nxt_word = '0;
            default:                    nxt_word = samp_in;
        endcase
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= samp_vld;
            if (samp_vld) word_out <= nxt_word;
        end
    end

    // R11: output valid trails input valid by one cycle
    a_r11_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld |=> word_vld);
    a_r11_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_vld |=> (!word_vld && $stable(word_out)));

    // R3: checkerboard only ever produces its two patterns
    a_r3_check_values: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_CHECK && samp_vld) |=>
            (word_out == PAT_CHK_A || word_out == PAT_CHK_B));

    // R4: toggle only ever produces all ones or all zeros
    a_r4_toggle_values: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_TOGGLE && samp_vld) |=>
            (word_out == '1 || word_out == '0));

    // R9: finished single shot emits zeros
    a_r9_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_ONCE_DONE && samp_vld) |=> (word_out == '0));

endmodule

// File: tb/lnk_tpg_top_tb.sv
`timescale 1ns/1ps
module lnk_tpg_top_tb;

    typedef struct {
        logic [15:0] d;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode_sel = 4'h0;
    logic [15:0] samp_in = '0;
    logic        samp_vld = 1'b0;
    logic        uw_wr = 1'b0;
    logic [1:0]  uw_addr = '0;
    logic [15:0] uw_data = '0;
    logic [15:0] word_out;
    logic        word_vld;

    always #2 clk = ~clk;

    lnk_tpg_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .samp_in  (samp_in),
        .samp_vld (samp_vld),
        .uw_wr    (uw_wr),
        .uw_addr  (uw_addr),
        .uw_data  (uw_data),
        .word_out (word_out),
        .word_vld (word_vld)
    );

    int checks = 0;
    int fails  = 0;
    exp_t sb_q[$];
    string cur_tag = "R1";

    // capture buffer for period checks
    logic [15:0] hist [520];
    int          cap_n = 0;
    bit          cap_on = 1'b0;

    // reference model state
    logic [3:0]  m_prev = 4'h0;
    logic        m_phase = 1'b0;
    logic [15:0] m_ramp = '0;
    int          m_idx = 0;
    bit          m_done = 1'b0;
    logic [31:0] m_lfsr [5];
    logic [15:0] m_user [4];

    function automatic int plen(input int i);
        case (i) 0: return 31; 1: return 23; 2: return 15; 3: return 9; default: return 7; endcase
    endfunction
    function automatic int ptap(input int i);
        case (i) 0: return 28; 1: return 18; 2: return 14; 3: return 5; default: return 6; endcase
    endfunction

    task automatic model_restart();
        m_phase = 1'b0;
        m_ramp  = '0;
        m_idx   = 0;
        m_done  = 1'b0;
        for (int i = 0; i < 5; i++) m_lfsr[i] = (32'h1 << plen(i)) - 1;
    endtask

    task automatic lfsr_word(input int k, output logic [15:0] w);
        logic [31:0] s;
        logic        fb;
        int n;
        int t;
        n = plen(k);
        t = ptap(k);
        s = m_lfsr[k];
        for (int i = 0; i < 16; i++) begin
            fb = s[n-1] ^ s[t-1];
            w[15-i] = fb;
            s = ((s << 1) | {31'd0, fb}) & ((32'h1 << n) - 1);
        end
        m_lfsr[k] = s;
    endtask

    task automatic model_word(input logic [3:0] m, input logic [15:0] smp, output logic [15:0] e);
        case (m)
            4'h1: begin e = m_phase ? 16'h5555 : 16'hAAAA; m_phase = ~m_phase; end
            4'h2: begin e = m_phase ? 16'h0000 : 16'hFFFF; m_phase = ~m_phase; end
            4'h3, 4'h4, 4'h5, 4'h6, 4'h7: lfsr_word(int'(m) - 3, e);
            4'h8: begin e = m_ramp; m_ramp = m_ramp + 16'd1; end
            4'hE: begin e = m_user[m_idx]; m_idx = (m_idx + 1) % 4; end
            4'hF: begin
                if (m_done) e = 16'h0000;
                else begin
                    e = m_user[m_idx];
                    if (m_idx == 3) begin m_done = 1'b1; m_idx = 0; end
                    else m_idx = m_idx + 1;
                end
            end
            default: e = smp;
        endcase
    endtask

    // driver: one cycle of stimulus, expected word pushed to the scoreboard
    task automatic send(input logic [3:0] m, input logic [15:0] d, input bit v);
        logic [15:0] e;
        exp_t it;
        @(negedge clk);
        mode_sel = m;
        samp_in  = d;
        samp_vld = v;
        if (m != m_prev) model_restart();
        m_prev = m;
        if (v) begin
            model_word(m, d, e);
            it.d   = e;
            it.tag = cur_tag;
            sb_q.push_back(it);
        end
    endtask

    task automatic burst(input logic [3:0] m, input int n, input int gap_every);
        for (int i = 0; i < n; i++) begin
            send(m, 16'(i * 16'h1357 + 16'h00C3), 1'b1);
            if (gap_every > 0 && (i % gap_every) == gap_every - 1) send(m, 16'hDEAD, 1'b0);
        end
    endtask

    task automatic wr_user(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        samp_vld = 1'b0;
        uw_wr    = 1'b1;
        uw_addr  = a;
        uw_data  = d;
        m_user[a] = d;
        @(negedge clk);
        uw_wr = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        samp_vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops and compares as results appear
    always @(negedge clk) begin
        if (rst_n && word_vld) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R11 unexpected word_vld", word_out, 16'h0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                check(word_out === it.d, it.tag, word_out, it.d);
                if (cap_on && cap_n < 520) begin
                    hist[cap_n] = word_out;
                    cap_n++;
                end
            end
        end
    end

    task automatic period_check(input logic [3:0] m, input int per, input string req);
        bit distinct;
        cap_n  = 0;
        cap_on = 1'b1;
        burst(m, per + 1, 0);
        drain();
        cap_on = 1'b0;
        check(cap_n == per + 1, {req, " capture count"}, 16'(cap_n), 16'(per + 1));
        check(hist[per] == hist[0], {req, " period repeat"}, hist[per], hist[0]);
        distinct = 1'b1;
        for (int i = 1; i < per; i++) if (hist[i] == hist[0]) distinct = 1'b0;
        check(distinct, {req, " no early repeat"}, 16'(distinct), 16'h1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] held;
        for (int i = 0; i < 4; i++) m_user[i] = '0;
        model_restart();
        repeat (4) @(negedge clk);
        // R1: outputs quiet during reset
        check(word_vld == 1'b0, "R1 vld in reset", {15'd0, word_vld}, 16'h0);
        check(word_out == 16'h0, "R1 word in reset", word_out, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_vld == 1'b0, "R1 vld after reset", {15'd0, word_vld}, 16'h0);
        check(word_out == 16'h0, "R1 word after reset", word_out, 16'h0);

        // R2: normal and unlisted codes pass samples
        cur_tag = "R2 normal";    burst(4'h0, 6, 2);
        cur_tag = "R2 code 1001"; burst(4'h9, 3, 0);
        cur_tag = "R2 code 1100"; burst(4'hC, 3, 0);
        cur_tag = "R2 code 1101"; burst(4'hD, 3, 0);
        drain();

        // R11: idle cycles hold the output
        held = word_out;
        send(4'hD, 16'h1234, 1'b0);
        send(4'hD, 16'h4321, 1'b0);
        @(negedge clk);
        check(word_vld == 1'b0, "R11 idle vld", {15'd0, word_vld}, 16'h0);
        check(word_out == held, "R11 idle hold", word_out, held);

        // R3, R4
        cur_tag = "R3 checkerboard"; burst(4'h1, 6, 0);
        cur_tag = "R4 toggle";       burst(4'h2, 6, 3);

        // R5: every polynomial against the model
        cur_tag = "R5 x31"; burst(4'h3, 40, 7);
        cur_tag = "R5 x23"; burst(4'h4, 40, 0);
        cur_tag = "R5 x15"; burst(4'h5, 40, 5);
        cur_tag = "R5 x9";  burst(4'h6, 40, 0);
        cur_tag = "R5 x7";  burst(4'h7, 40, 0);
        drain();

        // R6: periods of the short sequences
        cur_tag = "R6 x7 words"; send(4'h0, 16'h0, 1'b0);
        period_check(4'h7, 127, "R6 x7");
        cur_tag = "R6 x9 words"; send(4'h0, 16'h0, 1'b0);
        period_check(4'h6, 511, "R6 x9");

        // R7: ramp including the wrap
        cur_tag = "R7 ramp"; burst(4'h8, 65540, 0);
        drain();

        // R8: user pattern loop
        wr_user(2'd0, 16'hC0DE);
        wr_user(2'd1, 16'h0001);
        wr_user(2'd2, 16'h8000);
        wr_user(2'd3, 16'h7E57);
        cur_tag = "R8 user loop"; burst(4'hE, 10, 3);

        // R9: single shot, then zeros, then restart after a mode change
        cur_tag = "R9 single shot"; burst(4'hF, 9, 4);
        cur_tag = "R9 leave";       burst(4'h0, 1, 0);
        cur_tag = "R9 single again"; burst(4'hF, 6, 0);
        drain();

        // R10: restarts on mode change, including a change during idle
        cur_tag = "R10 ramp a";  burst(4'h8, 5, 0);
        cur_tag = "R10 check";   burst(4'h1, 3, 0);
        cur_tag = "R10 ramp b";  burst(4'h8, 3, 0);
        cur_tag = "R10 x7 a";    burst(4'h7, 10, 0);
        send(4'h6, 16'h0, 1'b0);
        cur_tag = "R10 x7 b";    burst(4'h7, 4, 0);
        cur_tag = "R10 user";    burst(4'hE, 2, 0);
        send(4'h2, 16'h0, 1'b0);
        cur_tag = "R10 user b";  burst(4'hE, 2, 0);
        drain();

        check(sb_q.size() == 0, "R11 scoreboard empty", 16'(sb_q.size()), 16'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule